// File: doc/BRIEF.md
# Power-Up Sequencer with Reset Generator

This block supervises the start of a group of supplies from a slow time base of roughly 10 kHz. The tick is supplied as a one-cycle enable on the block clock, so one tick is about 100 µs. When the power-on reset is released, the block asks for the trim fuses to be loaded. It then turns on the voltage reference and, after a programmable wait, the supply monitor. It starts three regulators in a fixed order once the monitored rail is reported good. Finally it drives a system reset: low for a long hold time, high for a short pulse, and after that equal to an external reset input.

The monitored-rail flag comes from a comparator that has its own hysteresis, with a 2.7 V rising threshold and a 2.6 V falling threshold. That flag and the external reset input are each filtered against glitches on both edges. If the rail drops at any point after the regulators begin to start, the block switches them off and pulls the reset low. The reference and the monitor are left running. The block then waits for the rail to come back and repeats the start without reloading the fuses. A per-regulator configuration bit can hold any regulator off independently of the sequence.

Top module: `pwrseq_rstgen`

## Requirements
- R1: While `por_n` is low, and after its release until `fuse_done` is seen on a tick, `fuse_load` is 1. In that time `ref_en`, `mon_en`, `reg_en` and `sys_rst_n` are all 0.
- R2: On clock cycles with `tick` low, no state changes, including the filters.
- R3: The first tick that sees `fuse_done` drops `fuse_load` and raises `ref_en`. `mon_en` rises exactly MON_WAIT ticks later, and both then stay high until `por_n` is asserted.
- R4: The filtered rail flag and the filtered external reset take a new level only after the raw input has held that level on DEB_TICKS consecutive ticks, on both rising and falling edges. A shorter excursion has no effect.
- R5: Regulators start only from the monitor-wait state, on the tick after the filtered rail flag is 1. `reg_en` bit 2 (regulator 3) comes on first. Bit 0 (regulator 1) follows STEP_TICKS ticks later, and bit 1 (regulator 2) follows 2*STEP_TICKS ticks after bit 2.
- R6: `sys_rst_n` stays 0 while the regulators start. It remains 0 for HOLD_TICKS ticks after the tick on which all three are on, then is 1 for exactly PULSE_TICKS ticks.
- R7: After the pulse, `sys_rst_n` equals the filtered `ext_rst_n`.
- R8: From the first regulator start onward, the tick after the filtered rail flag reads 0 clears all `reg_en` bits and forces `sys_rst_n` to 0. `ref_en` and `mon_en` stay 1 and `fuse_load` stays 0. The sequence then restarts from R5 when the rail is good again.
- R9: Each `reg_en` bit is the sequencer's enable for that regulator ANDed with the same bit of `reg_en_cfg`. The bit order is 0 = regulator 1, 1 = regulator 2, 2 = regulator 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| tick | input | 1 | One-cycle enable at about 10 kHz |
| fuse_done | input | 1 | Trim fuses have been loaded |
| sup_ok | input | 1 | Raw monitored-rail comparator flag (1 = good) |
| ext_rst_n | input | 1 | Raw external active-low reset request |
| reg_en_cfg | input | 3 | Per-regulator enable bits from a register |
| fuse_load | output | 1 | Request to load the trim fuses |
| ref_en | output | 1 | Voltage reference enable |
| mon_en | output | 1 | Supply monitor enable |
| reg_en | output | 3 | Regulator enables (bit 0 = regulator 1) |
| sys_rst_n | output | 1 | Active-low system reset output |

## Verification
The hardest situations to reach are a rail drop during the staggered regulator start and one during the reset hold. A drop only counts after the filter delay, so a drop aimed at a given sub-step has to be raised a filter delay ahead of it. The stimulus table is built around this. It drives the tick on every clock, so every state lasts a known number of cycles, and each rail drop is placed a fixed number of ticks into the phase under test. Single-tick glitches on both filtered inputs are placed next to full-length changes, so the table shows both that a glitch is rejected and that a real change takes effect.

// File: rtl/pwrseq_rstgen.sv
module pwrseq_rstgen #(
  parameter int MON_WAIT    = 40,
  parameter int STEP_TICKS  = 1,
  parameter int HOLD_TICKS  = 1800,
  parameter int PULSE_TICKS = 10,
  parameter int DEB_TICKS   = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       fuse_done,
  input  logic       sup_ok,
  input  logic       ext_rst_n,
  input  logic [2:0] reg_en_cfg,
  output logic       fuse_load,
  output logic       ref_en,
  output logic       mon_en,
  output logic [2:0] reg_en,
  output logic       sys_rst_n
);
  localparam int CW = $clog2(MON_WAIT + 2*STEP_TICKS + HOLD_TICKS + PULSE_TICKS + 2);
  localparam int DW = $clog2(DEB_TICKS) + 1;
  localparam logic [1:0] DB_INIT = 2'b10;

  typedef enum logic [2:0] {
    S_FUSE, S_REF, S_WAITSUP, S_START, S_HOLD, S_PULSE, S_RUN
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [1:0]    raw, db;
  logic [2:0]    seq_en;
  logic          sup_db, ext_db, powered;

  assign raw = {ext_rst_n, sup_ok};

  for (genvar i = 0; i < 2; i++) begin : g_deb
    logic          q;
    logic [DW-1:0] c;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        q <= DB_INIT[i];
        c <= '0;
      end else if (tick) begin
        if (raw[i] == q) c <= '0;
        else if (c == DW'(DEB_TICKS - 1)) begin
          q <= raw[i];
          c <= '0;
        end else c <= c + 1'b1;
      end
    end
    assign db[i] = q;
  end

  assign sup_db = db[0];
  assign ext_db = db[1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state <= S_FUSE;
      cnt   <= '0;
    end else if (tick) begin
      case (state)
        S_FUSE:
          if (fuse_done) begin
            state <= S_REF;
            cnt   <= '0;
          end
        S_REF:
          if (cnt == CW'(MON_WAIT - 1)) begin
            state <= S_WAITSUP;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        S_WAITSUP:
          if (sup_db) begin
            state <= S_START;
            cnt   <= '0;
          end
        default:
          if (!sup_db) begin
            state <= S_WAITSUP;
            cnt   <= '0;
          end else begin
            case (state)
              S_START:
                if (cnt == CW'(2*STEP_TICKS)) begin
                  state <= S_HOLD;
                  cnt   <= '0;
                end else cnt <= cnt + 1'b1;
              S_HOLD:
                if (cnt == CW'(HOLD_TICKS - 1)) begin
                  state <= S_PULSE;
                  cnt   <= '0;
                end else cnt <= cnt + 1'b1;
              S_PULSE:
                if (cnt == CW'(PULSE_TICKS - 1)) begin
                  state <= S_RUN;
                  cnt   <= '0;
                end else cnt <= cnt + 1'b1;
              default: cnt <= '0;
            endcase
          end
      endcase
    end
  end

  assign powered   = (state == S_HOLD) || (state == S_PULSE) || (state == S_RUN);
  assign seq_en[2] = powered || (state == S_START);
  assign seq_en[0] = powered || ((state == S_START) && (cnt >= CW'(STEP_TICKS)));
  assign seq_en[1] = powered || ((state == S_START) && (cnt >= CW'(2*STEP_TICKS)));

  assign fuse_load = (state == S_FUSE);
  assign ref_en    = (state != S_FUSE);
  assign mon_en    = (state != S_FUSE) && (state != S_REF);
  assign reg_en    = seq_en & reg_en_cfg;
  assign sys_rst_n = (state == S_PULSE) || ((state == S_RUN) && ext_db);

  AST_TICK_GATES_STATE: assert property (@(posedge clk) disable iff (!por_n)
    !tick |=> $stable(state)); // R2
  AST_REF_STAYS_ON: assert property (@(posedge clk) disable iff (!por_n)
    ref_en |=> ref_en && !fuse_load); // R3
  AST_START_NEEDS_SUP: assert property (@(posedge clk) disable iff (!por_n)
    $rose(seq_en[2]) |-> $past(sup_db)); // R5
  AST_ORDER_1_AFTER_3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(seq_en[0]) |-> $past(seq_en[2])); // R5
  AST_ORDER_2_AFTER_1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(seq_en[1]) |-> $past(seq_en[0])); // R5
  AST_ABORT_ON_FAIL: assert property (@(posedge clk) disable iff (!por_n)
    (tick && !sup_db && (seq_en != 3'b000)) |=> (seq_en == 3'b000) && !sys_rst_n && mon_en); // R8
  AST_RST_LOW_IN_START: assert property (@(posedge clk) disable iff (!por_n)
    (seq_en != 3'b111) |-> !sys_rst_n); // R6
endmodule

// File: tb/pwrseq_rstgen_bench.sv
`timescale 1ns/1ps
module pwrseq_rstgen_bench;
  logic       clk = 1'b0;
  logic       por_n, tick, fuse_done, sup_ok, ext_rst_n;
  logic [2:0] reg_en_cfg;
  logic       fuse_load, ref_en, mon_en, sys_rst_n;
  logic [2:0] reg_en;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pwrseq_rstgen #(.MON_WAIT(4), .STEP_TICKS(2), .HOLD_TICKS(10),
                  .PULSE_TICKS(3), .DEB_TICKS(2)) u_pwrseq_rstgen (
    .clk(clk), .por_n(por_n), .tick(tick), .fuse_done(fuse_done),
    .sup_ok(sup_ok), .ext_rst_n(ext_rst_n), .reg_en_cfg(reg_en_cfg),
    .fuse_load(fuse_load), .ref_en(ref_en), .mon_en(mon_en),
    .reg_en(reg_en), .sys_rst_n(sys_rst_n));

  // {req, steps, tick, fuse_done, sup_ok, ext_rst_n, cfg, exp ref, mon, fuse, reg[2:0], rst}
  localparam int NV = 33;
  localparam logic [25:0] VEC [NV] = '{
    {4'd1, 8'd3,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0}, // R1
    {4'd2, 8'd5,  1'b0, 1'b1, 1'b0, 1'b1, 3'b111, 1'b0, 1'b0, 1'b1, 3'b000, 1'b0}, // R2
    {4'd3, 8'd1,  1'b1, 1'b1, 1'b0, 1'b1, 3'b111, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0}, // R3
    {4'd3, 8'd3,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0}, // R3
    {4'd3, 8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}, // R3
    {4'd4, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}, // R4
    {4'd4, 8'd3,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}, // R4
    {4'd5, 8'd2,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}, // R5
    {4'd5, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b100, 1'b0}, // R5
    {4'd5, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b100, 1'b0}, // R5
    {4'd5, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b101, 1'b0}, // R5
    {4'd5, 8'd2,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b0}, // R5
    {4'd6, 8'd10, 1'b1, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b0}, // R6
    {4'd6, 8'd1,  1'b1, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1}, // R6
    {4'd6, 8'd2,  1'b1, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1}, // R6
    {4'd7, 8'd1,  1'b1, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b0}, // R7
    {4'd7, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b0}, // R7
    {4'd7, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1}, // R7
    {4'd4, 8'd1,  1'b1, 1'b0, 1'b1, 1'b0, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1}, // R4
    {4'd4, 8'd3,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1}, // R4
    {4'd9, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 3'b010, 1'b1, 1'b1, 1'b0, 3'b010, 1'b1}, // R9
    {4'd9, 8'd1,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1}, // R9
    {4'd4, 8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1}, // R4
    {4'd4, 8'd3,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1}, // R4
    {4'd8, 8'd2,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b1}, // R8
    {4'd8, 8'd1,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}, // R8
    {4'd8, 8'd5,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}, // R8
    {4'd8, 8'd3,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b100, 1'b0}, // R8
    {4'd8, 8'd3,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}, // R8
    {4'd8, 8'd3,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b100, 1'b0}, // R8
    {4'd8, 8'd4,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b0}, // R8
    {4'd8, 8'd3,  1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b111, 1'b0}, // R8
    {4'd8, 8'd3,  1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0}  // R8
  };

  task automatic check(input int req, input logic [6:0] exp);
    logic [6:0] got;
    got = {ref_en, mon_en, fuse_load, reg_en, sys_rst_n};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d at %0t: got %b expected %b (ref mon fuse reg[2:0] rst)",
               req, $time, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    por_n = 1'b0; tick = 1'b1; fuse_done = 1'b0; sup_ok = 1'b0;
    ext_rst_n = 1'b1; reg_en_cfg = 3'b111;
    repeat (3) @(negedge clk);
    check(1, 7'b0010000); // R1 reset state
    por_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      tick       = VEC[v][13];
      fuse_done  = VEC[v][12];
      sup_ok     = VEC[v][11];
      ext_rst_n  = VEC[v][10];
      reg_en_cfg = VEC[v][9:7];
      for (int s = 0; s < int'(VEC[v][21:14]); s++) begin
        @(posedge clk);
        @(negedge clk);
      end
      check(int'(VEC[v][25:22]), VEC[v][6:0]);
    end
    // R1: power-on reset asserted mid-sequence returns to the fuse-load state
    por_n = 1'b0;
    #1;
    check(1, 7'b0010000);
    // R8/R3: after release, fuses are requested again only because of the reset
    sup_ok = 1'b1;
    @(negedge clk);
    por_n = 1'b1;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(1, 7'b0010000);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got running expected finished");
      summary();
      $finish;
    end
  end
endmodule